// File: doc/BRIEF.md
# Ramp-Compare Multichannel Capture Timer

This block is the digital timing core of a single-slope converter. An external fixed current charges a capacitor to produce a rising ramp. A sync request discharges the capacitor for a programmable number of clock cycles. When the discharge ends, one shared timer starts counting.

Each of four comparator inputs watches the ramp against its own analog input. Three of them are direct channels. The fourth comes through an auxiliary multiplexer whose last code selects the internal reference, so the ramp slope can be calibrated. When a comparator trips, its result register takes the timer value. The block also drives the auxiliary select, a current-trim code and a calibration flag.

The timer counts either on every clock or on every second clock. Slow mode doubles the span of the ramp that the timer can cover.

Top module: `ramp_adc_capture`

## Requirements
- R1: A sync request taken while `cap_rst_o` is low raises `cap_rst_o` on the next clock. It then stays high for exactly `max(sync_len_i,1)` cycles. A request that arrives while `cap_rst_o` is high is ignored.
- R2: The shared timer reads zero for as long as `cap_rst_o` is high.
- R3: With `rate_fast_i`=1 the timer advances on every clock after the reset window. With `rate_fast_i`=0 it advances on every second clock, and the first step comes on the second clock after the window.
- R4: The timer saturates at all ones (2^TW-1) and stays there until the next sync.
- R5: A comparator rising edge passes through a two-flop synchronizer. The channel then stores the timer value that is present two clocks after its input rose, and sets its `valid_o` bit.
- R6: Only the first rising edge in a sync period is stored. Later edges leave the result and the valid bit unchanged.
- R7: A channel that has not captured by the next sync start is loaded with all ones.
- R8: Every `valid_o` bit clears on the clock that starts a sync.
- R9: A rising edge that is detected while `cap_rst_o` is high is not captured.
- R10: `aux_sel_o` takes `aux_sel_i` one clock later. The codes are 00, 01 and 10 for the auxiliary inputs and 11 for the reference. `ref_cal_o` is high exactly when the registered code is 11.
- R11: `trim_o` takes the 3-bit current-trim code `trim_i` one clock later.
- R12: After reset all results, valid bits, `cap_rst_o`, `aux_sel_o` and `trim_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_req_i | input | 1 | Sync request, starts a ramp period |
| sync_len_i | input | LEN_W | Capacitor reset length in clocks (0 is treated as 1) |
| rate_fast_i | input | 1 | 1: count every clock, 0: count every second clock |
| aux_sel_i | input | 2 | Auxiliary mux code |
| trim_i | input | TRIM_W | Ramp current trim code |
| cmp_i | input | N_MAIN+1 | Asynchronous comparator outputs; the top bit is the auxiliary channel |
| cap_rst_o | output | 1 | Capacitor discharge enable |
| aux_sel_o | output | 2 | Registered auxiliary mux code |
| ref_cal_o | output | 1 | Reference selected for calibration |
| trim_o | output | TRIM_W | Registered trim code |
| result_o | output | (N_MAIN+1)*TW | Captured counts, channel k at bits k*TW upward |
| valid_o | output | N_MAIN+1 | Per-channel capture flag |

## Verification
The bench builds the block with TW=6 and LEN_W=4. With these values the timer reaches saturation within about 65 clocks, so channels that trip after saturation can be reached in short periods. A zero-length reset window and a request arriving during an active window also come within reach in a short run. The bench checks slow and fast count rates and comparator edges both just before and just after the reset window ends. It also checks bouncing comparators and channels that never trip, against counts it works out from the requirement formulas.

// File: rtl/ramp_adc_pkg.sv
`timescale 1ns/1ps
package ramp_adc_pkg;
  localparam int unsigned AUX_W       = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [AUX_W-1:0] {
    AUX_IN0  = 2'b00,
    AUX_IN1  = 2'b01,
    AUX_IN2  = 2'b10,
    AUX_VREF = 2'b11
  } aux_sel_e;
endpackage

// File: rtl/ramp_sync_gen.sv
`timescale 1ns/1ps
module ramp_sync_gen #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             hold_o,
  output logic             start_o
);
  logic             hold_q;
  logic [LEN_W-1:0] cnt_q;

  assign start_o = req_i & ~hold_q;
  assign hold_o  = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      hold_q <= 1'b1;
      cnt_q  <= (len_i == '0) ? '0 : len_i - 1'b1;
    end else if (hold_q) begin
      if (cnt_q == '0) hold_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  p_start_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> hold_o);
  p_len_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && cnt_q != '0) |=> hold_o);
  p_len_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && cnt_q == '0) |=> !hold_o);
endmodule

// File: rtl/ramp_timer.sv
`timescale 1ns/1ps
module ramp_timer #(
  parameter int unsigned TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          fast_i,
  output logic [TW-1:0] cnt_o
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic          phase_q;
  logic          tick;
  logic [TW-1:0] cnt_q;

  assign tick  = fast_i | phase_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_o == '0);
  p_unit_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> (cnt_o - $past(cnt_o)) <= TW'(1));
  p_sat_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/ramp_chan.sv
`timescale 1ns/1ps
module ramp_chan
  import ramp_adc_pkg::*;
#(
  parameter int unsigned TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmp_i,
  input  logic          start_i,
  input  logic          hold_i,
  input  logic [TW-1:0] cnt_i,
  output logic [TW-1:0] res_o,
  output logic          vld_o
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  // stages 0..SYNC_STAGES-1 synchronize, last stage holds the previous value for edge detect
  logic [SYNC_STAGES:0] sh_q;
  logic                 rise;
  logic [TW-1:0]        res_q;
  logic                 vld_q;

  assign rise  = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign res_o = res_q;
  assign vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], cmp_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else if (start_i) begin
      vld_q <= 1'b0;
      if (!vld_q) res_q <= CNT_MAX;
    end else if (!hold_i && rise && !vld_q) begin
      res_q <= cnt_i;
      vld_q <= 1'b1;
    end
  end

  p_cap_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> res_o == $past(cnt_i));
  p_first_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !start_i) |=> ($stable(res_o) && vld_o));
  p_miss_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !vld_o) |=> res_o == CNT_MAX);
  p_vld_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !vld_o);
  p_hold_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !vld_o && !start_i) |=> !vld_o);
endmodule

// File: rtl/ramp_adc_capture.sv
`timescale 1ns/1ps
module ramp_adc_capture
  import ramp_adc_pkg::*;
#(
  parameter int unsigned TW     = 12,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned N_MAIN = 3,
  parameter int unsigned TRIM_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sync_req_i,
  input  logic [LEN_W-1:0]           sync_len_i,
  input  logic                       rate_fast_i,
  input  logic [AUX_W-1:0]           aux_sel_i,
  input  logic [TRIM_W-1:0]          trim_i,
  input  logic [N_MAIN:0]            cmp_i,
  output logic                       cap_rst_o,
  output logic [AUX_W-1:0]           aux_sel_o,
  output logic                       ref_cal_o,
  output logic [TRIM_W-1:0]          trim_o,
  output logic [(N_MAIN+1)*TW-1:0]   result_o,
  output logic [N_MAIN:0]            valid_o
);
  localparam int unsigned NCH = N_MAIN + 1;

  logic          hold;
  logic          start;
  logic [TW-1:0] cnt;
  aux_sel_e      aux_q;
  logic [TRIM_W-1:0] trim_q;

  ramp_sync_gen #(.LEN_W(LEN_W)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (sync_req_i),
    .len_i   (sync_len_i),
    .hold_o  (hold),
    .start_o (start)
  );

  ramp_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .fast_i (rate_fast_i),
    .cnt_o  (cnt)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    ramp_chan #(.TW(TW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cmp_i   (cmp_i[k]),
      .start_i (start),
      .hold_i  (hold),
      .cnt_i   (cnt),
      .res_o   (result_o[k*TW +: TW]),
      .vld_o   (valid_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_q  <= AUX_IN0;
      trim_q <= '0;
    end else begin
      aux_q  <= aux_sel_e'(aux_sel_i);
      trim_q <= trim_i;
    end
  end

  assign cap_rst_o = hold;
  assign aux_sel_o = aux_q;
  assign ref_cal_o = (aux_q == AUX_VREF);
  assign trim_o    = trim_q;
endmodule

// File: tb/sim_ramp_adc_capture.sv
`timescale 1ns/1ps
module sim_ramp_adc_capture;
  localparam int TW     = 6;
  localparam int LEN_W  = 4;
  localparam int N_MAIN = 3;
  localparam int NCH    = N_MAIN + 1;
  localparam int CMAX   = (1 << TW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sync_req = 1'b0;
  logic [LEN_W-1:0]     sync_len = '0;
  logic                 rate_fast = 1'b1;
  logic [1:0]           aux_sel = '0;
  logic [2:0]           trim = '0;
  logic [NCH-1:0]       cmp = '0;
  logic                 cap_rst;
  logic [1:0]           aux_sel_o;
  logic                 ref_cal;
  logic [2:0]           trim_o;
  logic [NCH*TW-1:0]    result;
  logic [NCH-1:0]       valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [NCH*TW-1:0] exp_res_q[$];
  logic [NCH-1:0]    exp_vld_q[$];

  always #2.5 clk = ~clk;

  ramp_adc_capture #(.TW(TW), .LEN_W(LEN_W), .N_MAIN(N_MAIN), .TRIM_W(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_req_i(sync_req), .sync_len_i(sync_len),
    .rate_fast_i(rate_fast), .aux_sel_i(aux_sel), .trim_i(trim), .cmp_i(cmp),
    .cap_rst_o(cap_rst), .aux_sel_o(aux_sel_o), .ref_cal_o(ref_cal), .trim_o(trim_o),
    .result_o(result), .valid_o(valid)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected capture per R3/R5/R9: trip first seen at edge d after the start edge
  function automatic int exp_val(int d, int w, bit fast);
    int weff = (w == 0) ? 1 : w;
    int k    = d + 1 - weff;
    int v    = fast ? k : k / 2;
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic bit exp_hit(int d, int w);
    int weff = (w == 0) ? 1 : w;
    return (d >= 1) && (d >= weff - 1);
  endfunction

  task automatic period(int w, bit fast, int aux, int tr, int d0, int d1, int d2, int d3,
                        bit [NCH-1:0] bounce, bit extra_req, int plen);
    int d[NCH];
    int rst_cnt = 0;
    int weff = (w == 0) ? 1 : w;
    logic [NCH*TW-1:0] er = '0;
    logic [NCH-1:0]    ev = '0;
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    @(negedge clk);
    sync_req  = 1'b1;
    sync_len  = LEN_W'(w);
    rate_fast = fast;
    aux_sel   = 2'(aux);
    trim      = 3'(tr);
    cmp       = '0;
    for (int c = 1; c < plen; c++) begin
      @(negedge clk);
      sync_req = extra_req && (c == 2);
      if (cap_rst) rst_cnt++;
      for (int ch = 0; ch < NCH; ch++)
        cmp[ch] = (d[ch] >= 1) && (c >= d[ch]) &&
                  !(bounce[ch] && c >= d[ch] + 3 && c < d[ch] + 6);
    end
    check("R1 reset window length", rst_cnt, weff);
    check("R10 aux select", int'(aux_sel_o), aux);
    check("R10 ref cal flag", int'(ref_cal), (aux == 3) ? 1 : 0);
    check("R11 trim code", int'(trim_o), tr);
    for (int ch = 0; ch < NCH; ch++) begin
      ev[ch] = exp_hit(d[ch], w);
      er[ch*TW +: TW] = ev[ch] ? TW'(exp_val(d[ch], w, fast)) : TW'(CMAX);
    end
    exp_res_q.push_back(er);
    exp_vld_q.push_back(ev);
  endtask

  // monitor: at each sync start, compare valid bits then the held/filled results
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && sync_req && !cap_rst && exp_res_q.size() > 0) begin
        logic [NCH*TW-1:0] er;
        logic [NCH-1:0]    ev;
        er = exp_res_q.pop_front();
        ev = exp_vld_q.pop_front();
        check("R5/R6/R9 valid before sync", int'(valid), int'(ev));
        @(posedge clk);
        #1;
        for (int ch = 0; ch < NCH; ch++)
          check(ev[ch] ? "R5 R6 captured count" : "R7 miss loads max",
                int'(result[ch*TW +: TW]), int'(er[ch*TW +: TW]));
        check("R8 valid cleared at start", int'(valid), 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset result", int'(result), 0);
    check("R12 reset valid", int'(valid), 0);
    check("R12 reset cap", int'(cap_rst), 0);
    check("R12 reset aux", int'(aux_sel_o), 0);
    check("R12 reset trim", int'(trim_o), 0);
    // R5 R6: bounce on ch0, ch3 never trips (R7)
    period(4, 1'b1, 0, 5, 10, 20, 5, -1, 4'b0001, 1'b0, 40);
    // R9 boundary: ch0 trips one edge too early, ch1 exactly at window end
    period(6, 1'b1, 1, 2, 4, 5, 6, 30, 4'b0000, 1'b0, 40);
    // R3 slow rate
    period(3, 1'b0, 2, 7, 3, 10, 40, 100, 4'b0100, 1'b0, 140);
    // R4 saturation
    period(2, 1'b1, 3, 0, 70, 90, 3, 8, 4'b0000, 1'b0, 100);
    // R1 zero length, then a request during an active window
    period(0, 1'b1, 3, 4, 1, 2, 3, 4, 4'b0000, 1'b0, 20);
    period(8, 1'b1, 0, 1, 12, 7, 9, -1, 4'b1111, 1'b1, 40);
    period(5, 1'b0, 1, 6, 4, 5, 20, 60, 4'b0010, 1'b0, 160);
    // final start to flush the last expectation
    @(negedge clk);
    sync_req = 1'b1;
    cmp = '0;
    @(negedge clk);
    sync_req = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 flush drained", exp_res_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule